// File: doc/BRIEF.md
# Reloading System Tick Timer

A periodic tick source built around a 24-bit down counter. Once enabled, the counter steps down by one on every selected tick. The tick is either every core clock cycle or each cycle on which an external reference strobe is high. When the counter passes from one to zero, a sticky count flag is raised. If interrupts are enabled, a tick request also becomes pending. On the next tick after zero the counter reloads from the reload register, so the period is the reload value plus one.

Software reaches the block through a small synchronous register port. The port has an address, a write enable, write data, a read enable and registered read data. There are five registers: control/status, reload, current value, a read-only calibration word, and a pending-request control register that sets or clears the tick request. The pending request leaves the block on `irq_req` for an external interrupt controller.

Top module: `systick_timer`

## Requirements
- R1: After reset, the control/status (address 0), reload (address 1), current (address 2) and pending (address 4) registers all read as zero, and `irq_req` is low.
- R2: Address 3 reads as the calibration word. Bits 23:0 hold the parameter `CAL_TENMS`, bit 30 (skew) is 0 and bit 31 (no external reference) is 0. Writes to it are ignored.
- R3: Control bit 0 enables counting. Control bit 2 selects the tick: 1 means every clock cycle, 0 means only cycles with `ext_tick` high. While bit 0 is 0 the count holds.
- R4: On a tick with a nonzero count, the count decreases by exactly one.
- R5: On a tick with a zero count, the count loads the reload register (bits 23:0 of address 1). A read of address 2 returns the live count.
- R6: The 1-to-0 transition sets the count flag, seen at bit 16 of address 0. The flag stays set until a read of address 0 returns it as 1, and that read clears it.
- R7: The 1-to-0 transition makes the tick request pending only when control bit 1 is set. `irq_req` is high while the request is pending.
- R8: A write to address 4 with bit 0 set makes the request pending. Bit 1 set removes it, and when both bits are set, the set wins. A read of address 4 returns the pending state in bit 0.
- R9: A write of any value to address 2 clears the count and the count flag, and raises no request.
- R10: With a reload value of zero, the counter stays at zero and raises neither flag nor request.
- R11: `rd_data` presents the addressed register one cycle after `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External reference tick strobe, one cycle per tick |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq_req | output | 1 | Pending tick request |

## Verification
The checker watches several rules on every cycle: each tick on a nonzero count lowers it by one, a 1-to-0 transition always leaves the flag set, and a disabled counter holds its value. It also checks that a write to the current value zeroes both count and flag, that a zero reload keeps the count at zero, and that a rising request always traces back to an enabled zero crossing or a set write. Other behaviours depend on the register protocol and only the bench scenarios show them. These are the clear-on-read of the flag, reload timing in both tick modes, set-wins on the pending register, the calibration word, and the read latency.

// File: rtl/systick_pkg.sv
package systick_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_RELOAD  = 3'd1,
    A_CURRENT = 3'd2,
    A_CALIB   = 3'd3,
    A_PEND    = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_RUN_BIT   = 0;
  localparam int unsigned CTRL_IRQEN_BIT = 1;
  localparam int unsigned CTRL_CORE_BIT  = 2;
  localparam int unsigned STAT_FLAG_BIT  = 16;
  localparam int unsigned CAL_SKEW_BIT   = 30;
  localparam int unsigned CAL_NOREF_BIT  = 31;
  localparam int unsigned PEND_SET_BIT   = 0;
  localparam int unsigned PEND_CLR_BIT   = 1;

  typedef struct packed {
    logic core_clk;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/systick_tick_sel.sv
module systick_tick_sel (
  input  logic run,
  input  logic core_clk,
  input  logic ext_tick,
  output logic tick
);
  always_comb begin
    tick = run & (core_clk | ext_tick);
  end
endmodule

// File: rtl/systick_counter.sv
module systick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  input  logic             flag_rd,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  always_comb begin
    zero_evt = tick && !clr && (cnt_q == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= ZERO;
      flag_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= ZERO;
      flag_q <= 1'b0;
    end else begin
      if (tick) begin
        cnt_q <= (cnt_q == ZERO) ? reload : cnt_q - ONE;
      end
      if (zero_evt) begin
        flag_q <= 1'b1;
      end else if (flag_rd) begin
        flag_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CAL_TENMS = 10499
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [CNT_W-1:0]      cnt,
  input  logic                  flag,
  input  logic                  zero_evt,
  output ctrl_t                 ctrl_q,
  output logic [CNT_W-1:0]      reload_q,
  output logic                  pend_q,
  output logic                  cur_wr,
  output logic                  flag_rd,
  output logic [DATA_W-1:0]     rd_data
);
  localparam logic [CNT_W-1:0] CAL_VAL = CNT_W'(CAL_TENMS);

  logic              pend_wr;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    cur_wr  = wr_en && (addr == A_CURRENT);
    pend_wr = wr_en && (addr == A_PEND);
    flag_rd = rd_en && (addr == A_CTRL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) begin
        ctrl_q <= ctrl_t'(wr_data[2:0]);
      end
      if (wr_en && addr == A_RELOAD) begin
        reload_q <= wr_data[CNT_W-1:0];
      end
      if ((zero_evt && ctrl_q.irq_en) || (pend_wr && wr_data[PEND_SET_BIT])) begin
        pend_q <= 1'b1;
      end else if (pend_wr && wr_data[PEND_CLR_BIT]) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      A_CTRL: begin
        rd_word[2:0]          = ctrl_q;
        rd_word[STAT_FLAG_BIT] = flag;
      end
      A_RELOAD:  rd_word[CNT_W-1:0] = reload_q;
      A_CURRENT: rd_word[CNT_W-1:0] = cnt;
      A_CALIB: begin
        rd_word[CNT_W-1:0]     = CAL_VAL;
        rd_word[CAL_SKEW_BIT]  = 1'b0;
        rd_word[CAL_NOREF_BIT] = 1'b0;
      end
      A_PEND:    rd_word[0] = pend_q;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_word;
    end
  end
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CAL_TENMS = 10499
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ext_tick,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  irq_req
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             zero_evt;
  logic             tick;
  logic             cur_wr;
  logic             flag_rd;
  logic             pend_q;

  systick_tick_sel u_tick (
    .run      (ctrl_q.run),
    .core_clk (ctrl_q.core_clk),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  systick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .clr      (cur_wr),
    .flag_rd  (flag_rd),
    .reload   (reload_q),
    .cnt_q    (cnt_q),
    .flag_q   (flag_q),
    .zero_evt (zero_evt)
  );

  systick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .CAL_TENMS(CAL_TENMS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_data  (wr_data),
    .cnt      (cnt_q),
    .flag     (flag_q),
    .zero_evt (zero_evt),
    .ctrl_q   (ctrl_q),
    .reload_q (reload_q),
    .pend_q   (pend_q),
    .cur_wr   (cur_wr),
    .flag_rd  (flag_rd),
    .rd_data  (rd_data)
  );

  always_comb begin
    irq_req = pend_q;
  end
endmodule

// File: rtl/systick_timer_chk.sv
module systick_timer_chk
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input logic                  clk,
  input logic                  rst,
  input logic [CNT_W-1:0]      cnt,
  input logic [CNT_W-1:0]      reload,
  input logic                  flag,
  input logic                  irq,
  input logic                  tick,
  input logic                  run,
  input logic                  irq_en,
  input logic                  cur_wr,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] addr,
  input logic                  set_bit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_step_down_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !cur_wr && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && !cur_wr) |=> $stable(cnt));

  assert_flag_on_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !cur_wr && cnt == ONE) |=> flag);

  assert_cur_write_clears_R9: assert property (@(posedge clk) disable iff (rst)
    cur_wr |=> (cnt == '0 && !flag));

  assert_zero_reload_stays_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && reload == '0 && !cur_wr) |=> (cnt == '0));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    (!irq && !(tick && !cur_wr && cnt == ONE && irq_en)
          && !(wr_en && addr == A_PEND && set_bit)) |=> !irq);
endmodule

bind systick_timer systick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt     (cnt_q),
  .reload  (reload_q),
  .flag    (flag_q),
  .irq     (irq_req),
  .tick    (tick),
  .run     (ctrl_q.run),
  .irq_en  (ctrl_q.irq_en),
  .cur_wr  (cur_wr),
  .wr_en   (wr_en),
  .addr    (addr),
  .set_bit (wr_data[0])
);

// File: tb/systick_timer_tb.sv
module systick_timer_tb;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ext_tick = 1'b0;
  logic [2:0]        addr = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq_req;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              sample_v = 1'b0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  systick_timer u_dut (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req)
  );

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DATA_W-1:0] e, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); ext_tick = 1'b1;
    @(negedge clk); ext_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq_req !== e) begin
      fails++;
      $display("FAIL %s irq_req actual=%0b expected=%0b", tag, irq_req, e);
    end
  endtask

  always @(posedge clk) sample_v <= rd_en;

  always @(negedge clk) begin
    if (sample_v && exp_q.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s rd_data actual=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(3'd0, 32'h0, "R1");
    rd(3'd1, 32'h0, "R1");
    rd(3'd2, 32'h0, "R1");
    rd(3'd4, 32'h0, "R1");
    // R2 calibration word, write ignored
    rd(3'd3, 32'h0000_2903, "R2");
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, 32'h0000_2903, "R2");
    // external tick mode, irq enabled
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h3);
    pulse(); rd(3'd2, 32'd3, "R5");
    pulse(); rd(3'd2, 32'd2, "R4");
    pulse(); rd(3'd0, 32'h3, "R6");
    chk_irq(1'b0, "R7");
    pulse(); chk_irq(1'b1, "R7");
    rd(3'd0, 32'h0001_0003, "R6");
    rd(3'd0, 32'h0000_0003, "R6");
    pulse(); rd(3'd2, 32'd3, "R5");
    rd(3'd4, 32'h1, "R8");
    // R8 pending control
    wr(3'd4, 32'h2); chk_irq(1'b0, "R8");
    rd(3'd4, 32'h0, "R8");
    wr(3'd4, 32'h1); chk_irq(1'b1, "R8");
    wr(3'd4, 32'h3); chk_irq(1'b1, "R8");
    wr(3'd4, 32'h2); chk_irq(1'b0, "R8");
    // R7 interrupt disabled
    wr(3'd0, 32'h1);
    pulse(); pulse(); pulse();
    chk_irq(1'b0, "R7");
    rd(3'd0, 32'h0001_0001, "R7");
    // R9 current write clears count and flag
    pulse(); pulse(); pulse(); pulse(); pulse();
    wr(3'd2, 32'h0000_0ABC);
    rd(3'd2, 32'h0, "R9");
    rd(3'd0, 32'h1, "R9");
    chk_irq(1'b0, "R9");
    // R3 disabled counter ignores ticks
    pulse();
    wr(3'd0, 32'h0);
    pulse(); pulse();
    rd(3'd2, 32'd3, "R3");
    // R10 zero reload
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h3);
    pulse(); pulse(); pulse();
    rd(3'd2, 32'h0, "R10");
    rd(3'd0, 32'h3, "R10");
    chk_irq(1'b0, "R10");
    // R3 core clock mode: five ticks then two ticks
    wr(3'd1, 32'd5);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h5);
    repeat (3) @(negedge clk);
    wr(3'd0, 32'h0);
    rd(3'd2, 32'd1, "R3");
    wr(3'd0, 32'h5);
    wr(3'd0, 32'h0);
    rd(3'd2, 32'd5, "R5");
    rd(3'd0, 32'h0001_0000, "R11");
    repeat (3) @(negedge clk);
    report();
  end
endmodule